// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Unit

This block is the on-chip data store of an 8-bit accumulator-style microcontroller. It keeps a 256-byte register-file RAM and steers each access to that RAM or to an outward special-register bus, depending on the addressing mode. Four client ports share the storage:
- a direct byte port;
- an indirect byte port whose address is held in pointer register R0 or R1;
- a register port that reaches R0 to R7 of the currently selected bank;
- a single-bit port that reads one bit and performs set/clear writes as a two-cycle read-modify-write.

The upper half of the byte address space has two meanings. A direct access there goes to the special-register bus, which serves the peripherals. An indirect access there goes to RAM. A 16-byte window of RAM, and every special register whose address ends in three zero bits, can be reached one bit at a time. Changing the bank-select value changes which eight RAM bytes the register port and the pointers use, and moves no data.

Top module: `idata_mem`

## Requirements
- R1: A direct access with address 0x00-0x7F reads RAM combinationally on `dir_rdata`; a direct write updates that RAM byte at the next clock edge.
- R2: A direct access with address 0x80-0xFF never touches RAM. It drives the special-register bus with `sfr_addr` = `dir_addr`, raises `sfr_re`/`sfr_we`, and returns `sfr_rdata` on `dir_rdata`.
- R3: The indirect port uses as its RAM address the byte stored in R0 (`ind_sel`=0) or R1 (`ind_sel`=1) of the active bank. It reaches all 256 RAM bytes, including 0x80-0xFF, and never the special-register bus.
- R4: Register Rn (`reg_idx`=n) of bank b lives at RAM byte b*8+n. A 2-bit bank value loaded with `bank_we` selects b. Switching banks leaves every RAM byte in place.
- R5: Bit address 0x00-0x7F selects bit position addr[2:0] of RAM byte 0x20+addr[6:3]. `bit_rdata` shows that bit combinationally.
- R6: Bit address 0x80-0xFF selects bit addr[2:0] of the special register at addr with bits [2:0] cleared. With `bit_re` high and the bus otherwise idle, it is read over the special-register bus, and bit writes to it go over that bus.
- R7: A `bit_req` seen while idle is accepted at a clock edge and raises `bit_busy` for the next cycle. At the following edge the target byte is rewritten with only bit `bit_val` changed, and `bit_busy` falls.
- R8: When a busy bit write meets a same-cycle write to its RAM byte from another port, or a direct use of the special-register bus for a register target, the other access wins. The bit write waits one more cycle and then modifies the newly written byte.
- R9: Writes from several ports to one RAM byte in one cycle resolve with this priority: direct, then indirect, then register.
- R10: Reset is synchronous and active low. It returns the bank select to 0 and `bit_busy` to 0, and leaves RAM contents unchanged.
- R11: A `bit_req` presented while `bit_busy` is high is ignored. The pending write keeps its target, and the new target bit is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_we | input | 1 | Load bank select |
| bank_wdata | input | 2 | New bank number |
| dir_addr | input | 8 | Direct byte address |
| dir_re | input | 1 | Direct read strobe (needed for upper half) |
| dir_we | input | 1 | Direct write strobe |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| ind_sel | input | 1 | Pointer choice: 0 = R0, 1 = R1 |
| ind_we | input | 1 | Indirect write strobe |
| ind_wdata | input | 8 | Indirect write data |
| ind_rdata | output | 8 | Indirect read data |
| reg_idx | input | 3 | Working register number |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| bit_addr | input | 8 | Bit address |
| bit_re | input | 1 | Bit read request (needed for register bits) |
| bit_req | input | 1 | Start a bit write |
| bit_val | input | 1 | Value to write into the bit |
| bit_rdata | output | 1 | Value of addressed bit |
| bit_busy | output | 1 | Bit write in progress |
| sfr_addr | output | 8 | Special-register address |
| sfr_re | output | 1 | Special-register read strobe |
| sfr_we | output | 1 | Special-register write strobe |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data (combinational) |

## Verification
The bench builds the block with its defaults: four banks of eight registers and the bit window based at 0x20. With these values the pointer and register locations (bank*8+n) and the bit-to-byte mapping can be predicted by hand. The bench models the peripherals as a small register file behind the special-register bus. This makes it possible to check upper-half aliasing, where the same address holds different data for direct and for indirect access. It also exercises the bit read-modify-write on both RAM and special registers, including the stall against a colliding direct write.

// File: rtl/idata_pkg.sv
// Shared widths and types for the internal data memory unit.
// Assumes byte-wide data and an 8-bit byte address space.
package idata_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam int unsigned POS_W  = $clog2(DATA_W);
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/idata_bit_map.sv
// Translates a bit address into its containing byte and bit position.
// Lower half maps into the RAM bit window at BIT_BASE; upper half maps
// onto special registers whose address has the low POS_W bits clear.
module idata_bit_map
    import idata_pkg::*;
#(
    parameter addr_t BIT_BASE = 8'h20
) (
    input  addr_t bit_addr,
    output addr_t byte_addr,
    output pos_t  pos,
    output logic  is_sfr
);
    // Pure decode of the bit address fields.
    always_comb begin
        is_sfr = bit_addr[ADDR_W-1];
        pos    = bit_addr[POS_W-1:0];
        if (is_sfr)
            byte_addr = {bit_addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        else
            byte_addr = BIT_BASE + addr_t'(bit_addr[ADDR_W-2:POS_W]);
    end
endmodule

// File: rtl/idata_ram_array.sv
// Flop-based RAM with NWR prioritised write ports (port 0 highest),
// NRD combinational read ports and a chained pointer/indirect read.
// Contents have no reset; rst_n only qualifies the assertions.
module idata_ram_array
    import idata_pkg::*;
#(
    parameter int unsigned NWR = 4,
    parameter int unsigned NRD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWR-1:0]   we,
    input  addr_t            waddr [NWR],
    input  data_t            wdata [NWR],
    input  addr_t            rd_addr [NRD],
    output data_t            rd_data [NRD],
    input  addr_t            ptr_addr,
    output data_t            ptr_data,
    output data_t            ind_data
);
    data_t mem [DEPTH];

    // Apply writes lowest priority first so port 0 lands last.
    always_ff @(posedge clk) begin
        for (int p = NWR - 1; p >= 0; p--) begin
            if (we[p]) mem[waddr[p]] <= wdata[p];
        end
    end

    // One independent read mux per read port.
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rd_data[i] = mem[rd_addr[i]];
    end

    // Pointer fetch followed by the access it points at.
    assign ptr_data = mem[ptr_addr];
    assign ind_data = mem[addr_t'(ptr_data)];

    AST_RAM_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> mem[$past(waddr[0])] == $past(wdata[0])); // R9
endmodule

// File: rtl/idata_bit_engine.sv
// Two-cycle bit write sequencer: accepts a request when idle, holds the
// target while busy, and commits once no stall is signalled.
// Assumes the caller computes stall from colliding accesses.
module idata_bit_engine
    import idata_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_i,
    input  addr_t byte_i,
    input  pos_t  pos_i,
    input  logic  val_i,
    input  logic  stall_i,
    output logic  busy_o,
    output addr_t byte_o,
    output pos_t  pos_o,
    output logic  val_o,
    output logic  commit_o
);
    // Capture a request when idle; release after an unstalled busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            byte_o <= '0;
            pos_o  <= '0;
            val_o  <= 1'b0;
        end else if (!busy_o && req_i) begin
            busy_o <= 1'b1;
            byte_o <= byte_i;
            pos_o  <= pos_i;
            val_o  <= val_i;
        end else if (busy_o && !stall_i) begin
            busy_o <= 1'b0;
        end
    end

    assign commit_o = busy_o & ~stall_i;

    AST_BIT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && req_i |=> busy_o); // R7
    AST_BIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !stall_i |=> !busy_o); // R7
    AST_BIT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && stall_i |=> busy_o); // R8
    AST_BIT_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(byte_o) && $stable(pos_o) && $stable(val_o)); // R11
endmodule

// File: rtl/idata_mem.sv
// Internal data memory unit: 256-byte RAM, banked working registers,
// pointer-indirect access, bit window and a special-register bus for
// direct upper-half accesses. Assumes the peripherals answer sfr_rdata
// combinationally from sfr_addr.
module idata_mem
    import idata_pkg::*;
#(
    parameter int unsigned BANKS    = 4,
    parameter int unsigned REGS     = 8,
    parameter addr_t       BIT_BASE = 8'h20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bank_we,
    input  logic [$clog2(BANKS)-1:0]   bank_wdata,
    input  addr_t                      dir_addr,
    input  logic                       dir_re,
    input  logic                       dir_we,
    input  data_t                      dir_wdata,
    output data_t                      dir_rdata,
    input  logic                       ind_sel,
    input  logic                       ind_we,
    input  data_t                      ind_wdata,
    output data_t                      ind_rdata,
    input  logic [$clog2(REGS)-1:0]    reg_idx,
    input  logic                       reg_we,
    input  data_t                      reg_wdata,
    output data_t                      reg_rdata,
    input  addr_t                      bit_addr,
    input  logic                       bit_re,
    input  logic                       bit_req,
    input  logic                       bit_val,
    output logic                       bit_rdata,
    output logic                       bit_busy,
    output addr_t                      sfr_addr,
    output logic                       sfr_re,
    output logic                       sfr_we,
    output data_t                      sfr_wdata,
    input  data_t                      sfr_rdata
);
    localparam int unsigned BANK_W = $clog2(BANKS);
    localparam int unsigned REG_W  = $clog2(REGS);
    localparam int unsigned NWR    = 4;
    localparam int unsigned NRD    = 4;
    localparam int unsigned WP_DIR = 0, WP_IND = 1, WP_REG = 2, WP_BIT = 3;
    localparam int unsigned RP_DIR = 0, RP_REG = 1, RP_BIT = 2, RP_TGT = 3;

    logic [BANK_W-1:0] bank_q;
    addr_t ptr_loc, reg_loc, ptr_data_a;
    data_t ptr_data;
    logic  [NWR-1:0] ram_we;
    addr_t ram_waddr [NWR];
    data_t ram_wdata [NWR];
    addr_t ram_raddr [NRD];
    data_t ram_rdata [NRD];
    addr_t rd_byte, tgt_byte, req_byte;
    pos_t  rd_pos, tgt_pos, req_pos;
    logic  rd_sfr, req_sfr, tgt_val, commit, stall, tgt_sfr;
    logic  dir_ram, dir_sfr_use, ram_hit;
    data_t cur_byte, new_byte;

    // Bank select register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (bank_we) bank_q <= bank_wdata;
    end

    // Working register and pointer locations in the active bank.
    assign ptr_loc    = addr_t'({bank_q, {(REG_W-1){1'b0}}, ind_sel});
    assign reg_loc    = addr_t'({bank_q, reg_idx});
    assign ptr_data_a = addr_t'(ptr_data);

    // Classification of the direct access.
    assign dir_ram     = ~dir_addr[ADDR_W-1];
    assign dir_sfr_use = dir_addr[ADDR_W-1] & (dir_re | dir_we);

    idata_bit_map #(.BIT_BASE(BIT_BASE)) u_rd_map (
        .bit_addr(bit_addr), .byte_addr(rd_byte), .pos(rd_pos), .is_sfr(rd_sfr)
    );
    assign req_byte = rd_byte;
    assign req_pos  = rd_pos;
    assign req_sfr  = rd_sfr;

    idata_bit_engine u_engine (
        .clk(clk), .rst_n(rst_n), .req_i(bit_req), .byte_i(req_byte),
        .pos_i(req_pos), .val_i(bit_val), .stall_i(stall), .busy_o(bit_busy),
        .byte_o(tgt_byte), .pos_o(tgt_pos), .val_o(tgt_val), .commit_o(commit)
    );
    assign tgt_sfr = tgt_byte[ADDR_W-1];

    // Collision of the pending bit write with another RAM writer.
    assign ram_hit = (dir_we & dir_ram & (dir_addr == tgt_byte))
                   | (ind_we & (ptr_data_a == tgt_byte))
                   | (reg_we & (reg_loc == tgt_byte));
    assign stall = bit_busy & (tgt_sfr ? dir_sfr_use : ram_hit);

    // Read-modify step on the current target byte.
    always_comb begin
        cur_byte          = tgt_sfr ? sfr_rdata : ram_rdata[RP_TGT];
        new_byte          = cur_byte;
        new_byte[tgt_pos] = tgt_val;
    end

    // RAM port wiring in priority order.
    always_comb begin
        ram_we[WP_DIR]    = dir_we & dir_ram;
        ram_waddr[WP_DIR] = dir_addr;
        ram_wdata[WP_DIR] = dir_wdata;
        ram_we[WP_IND]    = ind_we;
        ram_waddr[WP_IND] = ptr_data_a;
        ram_wdata[WP_IND] = ind_wdata;
        ram_we[WP_REG]    = reg_we;
        ram_waddr[WP_REG] = reg_loc;
        ram_wdata[WP_REG] = reg_wdata;
        ram_we[WP_BIT]    = commit & ~tgt_sfr;
        ram_waddr[WP_BIT] = tgt_byte;
        ram_wdata[WP_BIT] = new_byte;
        ram_raddr[RP_DIR] = dir_addr;
        ram_raddr[RP_REG] = reg_loc;
        ram_raddr[RP_BIT] = rd_byte;
        ram_raddr[RP_TGT] = tgt_byte;
    end

    idata_ram_array #(.NWR(NWR), .NRD(NRD)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
        .wdata(ram_wdata), .rd_addr(ram_raddr), .rd_data(ram_rdata),
        .ptr_addr(ptr_loc), .ptr_data(ptr_data), .ind_data(ind_rdata)
    );

    // Special-register bus owner: direct port, then bit commit, then bit read.
    always_comb begin
        sfr_addr  = '0;
        sfr_re    = 1'b0;
        sfr_we    = 1'b0;
        sfr_wdata = '0;
        if (dir_sfr_use) begin
            sfr_addr  = dir_addr;
            sfr_re    = dir_re;
            sfr_we    = dir_we;
            sfr_wdata = dir_wdata;
        end else if (bit_busy && tgt_sfr) begin
            sfr_addr  = tgt_byte;
            sfr_re    = 1'b1;
            sfr_we    = 1'b1;
            sfr_wdata = new_byte;
        end else if (bit_re && req_sfr) begin
            sfr_addr  = rd_byte;
            sfr_re    = 1'b1;
        end
    end

    // Read data returned to the clients.
    assign dir_rdata = dir_ram ? ram_rdata[RP_DIR] : sfr_rdata;
    assign reg_rdata = ram_rdata[RP_REG];
    assign bit_rdata = rd_sfr ? sfr_rdata[rd_pos] : ram_rdata[RP_BIT][rd_pos];

    AST_SFR_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_re || sfr_we) |-> sfr_addr[ADDR_W-1]); // R2
    AST_DIR_UPPER_TO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we && !dir_ram |-> sfr_we && sfr_addr == dir_addr); // R2
    AST_BANK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> bank_q == '0 && !bit_busy); // R10
endmodule

// File: tb/tb_idata_mem.sv
module tb_idata_mem;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bank_we;
    logic [1:0] bank_wdata;
    logic [7:0] dir_addr, dir_wdata, dir_rdata;
    logic       dir_re, dir_we;
    logic       ind_sel, ind_we;
    logic [7:0] ind_wdata, ind_rdata;
    logic [2:0] reg_idx;
    logic       reg_we;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] bit_addr;
    logic       bit_re, bit_req, bit_val, bit_rdata, bit_busy;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
    logic       sfr_re, sfr_we;

    always #5 clk = ~clk;

    idata_mem dut (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .dir_addr(dir_addr), .dir_re(dir_re), .dir_we(dir_we),
        .dir_wdata(dir_wdata), .dir_rdata(dir_rdata), .ind_sel(ind_sel),
        .ind_we(ind_we), .ind_wdata(ind_wdata), .ind_rdata(ind_rdata),
        .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bit_addr(bit_addr), .bit_re(bit_re),
        .bit_req(bit_req), .bit_val(bit_val), .bit_rdata(bit_rdata),
        .bit_busy(bit_busy), .sfr_addr(sfr_addr), .sfr_re(sfr_re),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // Peripheral model: a plain register file behind the bus.
    logic [7:0] sfr_mem [128];
    assign sfr_rdata = sfr_mem[sfr_addr[6:0]];
    always @(posedge clk) if (sfr_we) sfr_mem[sfr_addr[6:0]] <= sfr_wdata;

    // Scoreboard.
    localparam int S_DIR = 0, S_IND = 1, S_REG = 2, S_BIT = 3, S_BUSY = 4;
    typedef struct { string tag; int sel; logic [7:0] exp; } item_t;
    item_t sb_q[$];
    event  chk_ev;
    int    checks = 0, errors = 0;
    bit    done = 0;

    function automatic logic [7:0] pick(int sel);
        case (sel)
            S_DIR:   return dir_rdata;
            S_IND:   return ind_rdata;
            S_REG:   return reg_rdata;
            S_BIT:   return {7'd0, bit_rdata};
            default: return {7'd0, bit_busy};
        endcase
    endfunction

    // Monitor: pops expected items and compares against live outputs.
    initial forever begin
        @(chk_ev);
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = pick(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk(string tag, int sel, logic [7:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        rst_n = 0; bank_we = 0; bank_wdata = 0; dir_addr = 0; dir_re = 0;
        dir_we = 0; dir_wdata = 0; ind_sel = 0; ind_we = 0; ind_wdata = 0;
        reg_idx = 0; reg_we = 0; reg_wdata = 0; bit_addr = 0; bit_re = 0;
        bit_req = 0; bit_val = 0;
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R10 busy low after reset", S_BUSY, 8'h00);

        // R1 direct lower half
        dir_addr = 8'h10; dir_we = 1; dir_wdata = 8'hA5; cyc(); dir_we = 0;
        chk("R1 direct 0x10", S_DIR, 8'hA5);
        dir_addr = 8'h7F; dir_we = 1; dir_wdata = 8'h3C; cyc(); dir_we = 0;
        chk("R1 direct 0x7F", S_DIR, 8'h3C);

        // R3 indirect to upper RAM via R0 of bank 0
        reg_idx = 0; reg_we = 1; reg_wdata = 8'h90; cyc(); reg_we = 0;
        ind_sel = 0; ind_we = 1; ind_wdata = 8'h11; cyc(); ind_we = 0;
        chk("R3 indirect upper RAM", S_IND, 8'h11);

        // R2 direct upper half goes to special registers
        dir_addr = 8'h90; dir_we = 1; dir_wdata = 8'h77; cyc(); dir_we = 0;
        dir_re = 1;
        chk("R2 direct upper reads bus", S_DIR, 8'h77);
        dir_re = 0;
        chk("R2 RAM 0x90 untouched", S_IND, 8'h11);

        // R3 pointer R1
        reg_idx = 1; reg_we = 1; reg_wdata = 8'h05; cyc(); reg_we = 0;
        ind_sel = 1; ind_we = 1; ind_wdata = 8'h66; cyc(); ind_we = 0;
        dir_addr = 8'h05;
        chk("R3 via R1", S_DIR, 8'h66);

        // R4 banks
        dir_addr = 8'h03; dir_we = 1; dir_wdata = 8'h44; cyc(); dir_we = 0;
        bank_we = 1; bank_wdata = 2; cyc(); bank_we = 0;
        reg_idx = 3; reg_we = 1; reg_wdata = 8'hB2; cyc(); reg_we = 0;
        dir_addr = 8'h13;
        chk("R4 bank2 R3 at 0x13", S_DIR, 8'hB2);
        bank_we = 1; bank_wdata = 0; cyc(); bank_we = 0;
        chk("R4 bank0 R3", S_REG, 8'h44);
        bank_we = 1; bank_wdata = 2; cyc(); bank_we = 0;
        chk("R4 bank2 R3 kept", S_REG, 8'hB2);

        // R10 reset clears bank, keeps RAM
        rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
        chk("R10 bank back to 0", S_REG, 8'h44);
        chk("R10 RAM kept", S_DIR, 8'hB2);

        // R5 bit window read
        dir_addr = 8'h2A; dir_we = 1; dir_wdata = 8'h10; cyc(); dir_we = 0;
        bit_addr = 8'h54;
        chk("R5 bit 0x54 set", S_BIT, 8'h01);
        bit_addr = 8'h53;
        chk("R5 bit 0x53 clear", S_BIT, 8'h00);

        // R7 bit write and R11 ignored request while busy
        bit_addr = 8'h50; bit_val = 1; bit_req = 1; cyc();
        chk("R7 busy after accept", S_BUSY, 8'h01);
        bit_addr = 8'h57; cyc(); bit_req = 0;
        chk("R7 busy falls", S_BUSY, 8'h00);
        chk("R7 byte 0x2A", S_DIR, 8'h11);
        chk("R11 second request ignored", S_BIT, 8'h00);

        // R6 special-register bits
        dir_addr = 8'h88; dir_we = 1; dir_wdata = 8'h05; cyc(); dir_we = 0;
        bit_re = 1; bit_addr = 8'h8A;
        chk("R6 bit 0x8A", S_BIT, 8'h01);
        bit_addr = 8'h89;
        chk("R6 bit 0x89", S_BIT, 8'h00);
        bit_re = 0;
        bit_req = 1; bit_val = 1; cyc(); bit_req = 0; cyc();
        dir_re = 1;
        chk("R6 register bit write", S_DIR, 8'h07);
        dir_re = 0;

        // R8 stall against a direct write to the same byte
        bit_addr = 8'h57; bit_val = 1; bit_req = 1; cyc(); bit_req = 0;
        dir_addr = 8'h2A; dir_we = 1; dir_wdata = 8'h02; cyc(); dir_we = 0;
        chk("R8 still busy", S_BUSY, 8'h01);
        chk("R8 direct wins", S_DIR, 8'h02);
        cyc();
        chk("R8 bit after stall", S_DIR, 8'h82);
        chk("R8 busy done", S_BUSY, 8'h00);

        // R9 write priority
        reg_idx = 0; reg_we = 1; reg_wdata = 8'h07; cyc(); reg_we = 0;
        ind_sel = 0; ind_we = 1; ind_wdata = 8'h55;
        reg_idx = 7; reg_we = 1; reg_wdata = 8'h99; cyc();
        ind_we = 0; reg_we = 0; dir_addr = 8'h07;
        chk("R9 indirect over register", S_DIR, 8'h55);
        dir_we = 1; dir_wdata = 8'hAA; ind_we = 1; ind_wdata = 8'h33; cyc();
        dir_we = 0; ind_we = 0;
        chk("R9 direct over indirect", S_DIR, 8'hAA);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule